// File: doc/BRIEF.md
# Multiframe Clock Generator with SYSREF Alignment

This block produces the local multiframe timing for a JESD204B subclass 1 receiver. It runs entirely in the device clock domain and counts octets within a frame and frames within a multiframe. It drives a one-cycle frame boundary marker and a one-cycle multiframe boundary marker. The multiframe length is K×F device clocks, with one octet per clock. K is the number of frames per multiframe, from 1 to 32. F is the number of octets per frame, from 1 to 8. Both are set on configuration inputs.

The boundary phase is set by an external SYSREF reference. The reference passes through a two-flop synchronizer, and only its rising edge is used. The pulse may be periodic, one-shot or gapped, and it may stay high for any length of time. A single-cycle software sync strobe from the register interface does the same realignment without SYSREF. Once the link is up, a mask input makes the logic ignore a free-running SYSREF.

Two sticky status flags are kept. The first shows that at least one realignment has taken place. The second records a SYSREF edge that arrived while aligned but away from the current multiframe boundary.

Top module: `lmfc_gen`

## Requirements
- R1: While rst_ni is low, lmfc_o=1, frame_o=1, aligned_o=0 and phase_err_o=0, because the octet and frame counters are both held at phase zero.
- R2: frame_o is high for one cycle out of every F cycles, where F = f_len_i+1 (f_len_i from 0 to 7).
- R3: lmfc_o is high for one cycle out of every K×F cycles, where K = k_len_i+1 (k_len_i from 0 to 31), and lmfc_o is high only when frame_o is also high.
- R4: When a SYSREF rise is first sampled at clock edge t, the cycle after edge t+1 is taken as phase zero. lmfc_o is therefore next high in the cycle that follows edge t+1+K×F.
- R5: Only the rising edge of sysref_i acts. A high pulse of 4 clocks is accepted, and a level held high for any length, or a 50% duty periodic SYSREF, causes no further realignment while it stays high.
- R6: When sw_sync_i is sampled high at clock edge t, the cycle that ends at edge t is taken as phase zero. lmfc_o is then next high after edge t+K×F−1, and aligned_o sets.
- R7: aligned_o is 0 until the first realignment (SYSREF or software), then stays 1 until reset.
- R8: A SYSREF edge that lands at phase zero while aligned_o=1 leaves the phase unchanged and does not set phase_err_o.
- R9: A SYSREF edge at a nonzero phase while aligned_o=1 sets phase_err_o, which stays set until reset, and realigns the counters. An edge before the first alignment never sets phase_err_o.
- R10: While sysref_mask_i=1, SYSREF edges cause no realignment and no change to aligned_o or phase_err_o. Clearing the mask while SYSREF is already high creates no edge.
- R11: A SYSREF edge and sw_sync_i in the same cycle give a single realignment and do not set phase_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sysref_i | input | 1 | Asynchronous SYSREF reference |
| sysref_mask_i | input | 1 | 1 = ignore SYSREF edges |
| sw_sync_i | input | 1 | One-cycle software realignment strobe |
| f_len_i | input | 3 | Octets per frame minus one |
| k_len_i | input | 5 | Frames per multiframe minus one |
| lmfc_o | output | 1 | Multiframe boundary pulse |
| frame_o | output | 1 | Frame boundary pulse |
| aligned_o | output | 1 | Sticky: a realignment has occurred |
| phase_err_o | output | 1 | Sticky: SYSREF edge seen off-boundary while aligned |

## Verification
The detected SYSREF edge and the software sync strobe can fall in the same clock cycle. To provoke this, the bench raises SYSREF at a phase chosen so that its synchronized edge lands at a nonzero phase. It then asserts sw_sync_i exactly two clocks later, in the cycle where that edge is seen. The result is judged by the distance to the next lmfc_o pulse, which must show one realignment, and by phase_err_o, which must stay clear. A masked SYSREF edge landing on an arbitrary phase is judged the same way, by an unchanged lmfc_o schedule.

// File: rtl/lmfc_gen_pkg.sv
package lmfc_gen_pkg;
  typedef enum logic [1:0] {
    ALIGN_NONE,
    ALIGN_SYSREF,
    ALIGN_SOFT
  } align_src_e;
endpackage

// File: rtl/lmfc_sysref_edge.sv
module lmfc_sysref_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sysref_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // prev_q tracks regardless of mask so unmasking while high creates no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], sysref_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/lmfc_phase_ctr.sv
module lmfc_phase_ctr #(
  parameter int OW = 3,
  parameter int KW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [OW-1:0] f_len_i,
  input  logic [KW-1:0] k_len_i,
  input  logic          load_i,
  output logic [OW-1:0] oct_o,
  output logic [KW-1:0] frm_o
);
  logic [OW-1:0] oct_q, oct_base, oct_d;
  logic [KW-1:0] frm_q, frm_base, frm_d;

  // load: current cycle counts as phase zero, next cycle is its successor
  always_comb begin
    oct_base = load_i ? '0 : oct_q;
    frm_base = load_i ? '0 : frm_q;
    if (oct_base >= f_len_i) begin
      oct_d = '0;
      frm_d = (frm_base >= k_len_i) ? '0 : frm_base + KW'(1);
    end else begin
      oct_d = oct_base + OW'(1);
      frm_d = frm_base;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oct_q <= '0;
      frm_q <= '0;
    end else begin
      oct_q <= oct_d;
      frm_q <= frm_d;
    end
  end

  assign oct_o = oct_q;
  assign frm_o = frm_q;
endmodule

// File: rtl/lmfc_align_track.sv
module lmfc_align_track
  import lmfc_gen_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_i,
  input  logic mask_i,
  input  logic sw_sync_i,
  input  logic at_zero_i,
  output logic load_o,
  output logic aligned_o,
  output logic phase_err_o
);
  align_src_e src;
  logic       aligned_q, err_q, err_set;

  always_comb begin
    if (sw_sync_i)             src = ALIGN_SOFT;
    else if (edge_i && !mask_i) src = ALIGN_SYSREF;
    else                       src = ALIGN_NONE;
  end

  assign load_o  = (src != ALIGN_NONE);
  assign err_set = (src == ALIGN_SYSREF) && aligned_q && !at_zero_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aligned_q <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      if (load_o)  aligned_q <= 1'b1;
      if (err_set) err_q     <= 1'b1;
    end
  end

  assign aligned_o   = aligned_q;
  assign phase_err_o = err_q;
endmodule

// File: rtl/lmfc_gen.sv
module lmfc_gen #(
  parameter int K_MAX       = 32,
  parameter int F_MAX       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sysref_i,
  input  logic                       sysref_mask_i,
  input  logic                       sw_sync_i,
  input  logic [$clog2(F_MAX)-1:0]   f_len_i,
  input  logic [$clog2(K_MAX)-1:0]   k_len_i,
  output logic                       lmfc_o,
  output logic                       frame_o,
  output logic                       aligned_o,
  output logic                       phase_err_o
);
  localparam int FW = $clog2(F_MAX);
  localparam int KW = $clog2(K_MAX);

  logic          sysref_edge;
  logic          realign;
  logic          at_zero;
  logic [FW-1:0] oct;
  logic [KW-1:0] frm;

  lmfc_sysref_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sysref_i (sysref_i),
    .edge_o   (sysref_edge)
  );

  lmfc_phase_ctr #(.OW(FW), .KW(KW)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .f_len_i (f_len_i),
    .k_len_i (k_len_i),
    .load_i  (realign),
    .oct_o   (oct),
    .frm_o   (frm)
  );

  assign at_zero = (oct == '0) && (frm == '0);

  lmfc_align_track u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_i      (sysref_edge),
    .mask_i      (sysref_mask_i),
    .sw_sync_i   (sw_sync_i),
    .at_zero_i   (at_zero),
    .load_o      (realign),
    .aligned_o   (aligned_o),
    .phase_err_o (phase_err_o)
  );

  assign lmfc_o  = at_zero;
  assign frame_o = (oct == '0);
endmodule

// File: rtl/lmfc_gen_chk.sv
module lmfc_gen_chk #(
  parameter int FW = 3,
  parameter int KW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sysref_mask_i,
  input logic          sw_sync_i,
  input logic [FW-1:0] f_len_i,
  input logic [KW-1:0] k_len_i,
  input logic          lmfc_o,
  input logic          frame_o,
  input logic          aligned_o,
  input logic          phase_err_o,
  input logic          sysref_edge
);
  assert_frame_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o && (f_len_i != '0) |=> !frame_o);

  assert_lmfc_on_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lmfc_o |-> frame_o);

  assert_edge_realign_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysref_edge && !sysref_mask_i |=> aligned_o);

  assert_sw_sync_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_sync_i && (f_len_i != '0) |=> aligned_o && !frame_o);

  assert_aligned_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aligned_o |=> aligned_o);

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_err_o |=> phase_err_o);

  assert_err_needs_aligned_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_err_o) |-> $past(aligned_o));

  assert_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sysref_mask_i && !sw_sync_i && !aligned_o |=> !aligned_o);

  assert_sw_no_err_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_sync_i && !phase_err_o |=> !phase_err_o);
endmodule

bind lmfc_gen lmfc_gen_chk #(.FW(FW), .KW(KW)) u_chk (.*);

// File: tb/lmfc_gen_test.sv
module lmfc_gen_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sysref = 1'b0;
  logic       mask = 1'b0;
  logic       sw_sync = 1'b0;
  logic [2:0] f_len = 3'd0;
  logic [4:0] k_len = 5'd0;
  logic       lmfc, frame, aligned, perr;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  lmfc_gen uut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .sysref_i      (sysref),
    .sysref_mask_i (mask),
    .sw_sync_i     (sw_sync),
    .f_len_i       (f_len),
    .k_len_i       (k_len),
    .lmfc_o        (lmfc),
    .frame_o       (frame),
    .aligned_o     (aligned),
    .phase_err_o   (perr)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int k, input int f);
    k_len = 5'(k - 1);
    f_len = 3'(f - 1);
  endtask

  task automatic period(input bit sel_lmfc, output int n);
    do @(negedge clk); while (!(sel_lmfc ? lmfc : frame));
    n = 0;
    do begin @(negedge clk); n++; end while (!(sel_lmfc ? lmfc : frame) && n < 1000);
  endtask

  task automatic goto_phase(input int m);
    do @(negedge clk); while (!lmfc);
    repeat (m) @(negedge clk);
  endtask

  // hold<0: SYSREF stays high; sw_at<0: no software strobe
  task automatic pulse_count(input int hold, input int sw_at, output int n);
    sysref  = (hold != 0);
    sw_sync = (sw_at == 0);
    n = -1;
    for (int j = 1; j < 600; j++) begin
      @(negedge clk);
      if (hold >= 0) sysref = (j < hold);
      sw_sync = (j == sw_at);
      if (j >= 3 && lmfc) begin n = j - 2; break; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int ks[4] = '{1, 2, 5, 32};
    localparam int KF = 8;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 lmfc", int'(lmfc), 1);
    check("R1 frame", int'(frame), 1);
    check("R1 aligned", int'(aligned), 0);
    check("R1 phase_err", int'(perr), 0);
    rst_ni = 1'b1;

    // R2/R3 sweep of frame and multiframe lengths
    for (int f = 1; f <= 8; f++) begin
      for (int ki = 0; ki < 4; ki++) begin
        set_cfg(ks[ki], f);
        period(1'b0, n);
        check("R2 frame period", n, f);
        period(1'b1, n);
        check("R3 lmfc period", n, ks[ki] * f);
      end
    end

    // K=4, F=2: multiframe of 8 clocks
    set_cfg(4, 2);
    repeat (4) @(negedge clk);
    check("R7 aligned before sync", int'(aligned), 0);
    pulse_count(4, -1, n);
    check("R4 first lmfc after 4-clock SYSREF", n, KF);
    check("R7 aligned after SYSREF", int'(aligned), 1);
    check("R9 no err before first alignment", int'(perr), 0);
    repeat (4) @(negedge clk);

    // R8 edge on boundary, held high indefinitely
    goto_phase(KF - 2);
    pulse_count(-1, -1, n);
    check("R8 boundary edge keeps phase", n, KF);
    check("R8 no err on boundary edge", int'(perr), 0);
    // R5/R6 software shift while SYSREF stays high
    pulse_count(-1, 0, n);
    check("R6 lmfc after soft sync", n, KF - 2);
    repeat (2 * KF) @(negedge clk);
    period(1'b1, n);
    check("R5 long high keeps soft phase", n, KF);
    check("R5 no err while held high", int'(perr), 0);
    sysref = 1'b0;
    repeat (4) @(negedge clk);

    // R9 off-boundary edge
    goto_phase(KF - 3);
    pulse_count(4, -1, n);
    check("R9 realign after off-boundary edge", n, KF);
    check("R9 phase_err set", int'(perr), 1);
    repeat (3 * KF) @(negedge clk);
    check("R9 phase_err sticky", int'(perr), 1);

    // fresh start for mask and coincidence cases
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    mask = 1'b1;
    pulse_count(4, -1, n);
    repeat (6) @(negedge clk);
    check("R10 masked edge leaves aligned clear", int'(aligned), 0);
    pulse_count(0, 0, n);
    check("R6 soft sync under mask", n, KF - 2);
    check("R6 aligned after soft sync", int'(aligned), 1);
    goto_phase(KF - 3);
    pulse_count(4, -1, n);
    check("R10 masked edge keeps phase", n, 1);
    check("R10 masked edge no err", int'(perr), 0);
    repeat (4) @(negedge clk);
    goto_phase(5);
    sysref = 1'b1;
    repeat (5) @(negedge clk);
    mask = 1'b0;
    repeat (6) @(negedge clk);
    check("R10 unmask while high no edge", int'(perr), 0);
    sysref = 1'b0;
    repeat (4) @(negedge clk);

    // R11 SYSREF edge and software strobe in the same cycle
    goto_phase(KF - 3);
    pulse_count(4, 2, n);
    check("R11 single realign", n, KF);
    check("R11 no err on coincidence", int'(perr), 0);
    check("R11 aligned", int'(aligned), 1);
    repeat (4) @(negedge clk);

    // R5 periodic 50% duty SYSREF, period 24
    goto_phase(KF - 2);
    for (int p = 0; p < 5; p++) begin
      sysref = 1'b1;
      repeat (12) @(negedge clk);
      sysref = 1'b0;
      repeat (12) @(negedge clk);
    end
    check("R5 periodic no err", int'(perr), 0);
    period(1'b1, n);
    check("R5 periodic lmfc period", n, KF);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule